// File: doc/BRIEF.md
# Integer Min/Max Execution Unit

This block is a 64-bit integer execution slice that handles four comparison-select operations: signed maximum, unsigned maximum, signed minimum and unsigned minimum. Each cycle it may accept one 32-bit instruction word together with the values of its two source registers. It decodes the instruction, picks one of the two operands, and returns the chosen value along with the destination register index and a register write enable. When the instruction's record bit is set, it also returns a 4-bit condition field that classifies the result as negative, positive or zero, with the summary-overflow input copied into its lowest bit.

An instruction word that does not carry one of the four encodings raises an illegal-instruction flag and requests no write. All outputs are registered and appear on the clock edge after the one that samples the input strobe. An issue stage drives the block; the results feed a writeback stage.

Top module: `minmax_unit`

## Requirements
- R1: Instruction bits use big-endian numbering, so word bit 0 is the MSB, `insn[31]`. The primary opcode in `insn[31:26]` must equal 22. The extended opcode in `insn[10:1]` selects the operation: 0b0111001110 is signed max, 0b0011001110 is unsigned max, 0b0101001110 is signed min and 0b0001001110 is unsigned min.
- R2: Signed max returns operand A only when A > B as two's-complement numbers. In every other case, equality included, it returns B.
- R3: Unsigned max returns A only when A > B as unsigned numbers. Otherwise it returns B.
- R4: Signed min returns A only when A < B as two's-complement numbers. Otherwise it returns B.
- R5: Unsigned min returns A only when A < B as unsigned numbers. Otherwise it returns B.
- R6: The record bit is `insn[0]`. When it is 1 on a legal instruction, the condition write enable is raised. The condition field is then 4'b1000 for a negative result, 4'b0100 for a positive result and 4'b0010 for a zero result, with bit 0 equal to the summary-overflow input. When the record bit is 0, the condition write enable stays low.
- R7: An instruction whose primary or extended opcode matches none of the encodings in R1 raises the illegal flag. It raises neither the register write enable nor the condition write enable.
- R8: Outputs are valid one clock after the edge that samples the input strobe high. In a cycle that follows an edge with the strobe low, the write enables and the illegal flag are all 0.
- R9: A synchronous active-high reset clears the write enables and the illegal flag.
- R10: The destination index output equals `insn[25:21]` of the accepted instruction. The source register fields in `insn[20:16]` and `insn[15:11]` do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| insn | input | 32 | Instruction word |
| opa | input | XLEN (64) | First source operand value |
| opb | input | XLEN (64) | Second source operand value |
| so_in | input | 1 | Summary-overflow bit, copied into the condition field |
| out_result | output | XLEN (64) | Selected operand |
| out_rt | output | 5 | Destination register index |
| out_wen | output | 1 | Register write enable |
| out_cr | output | 4 | Condition field |
| out_cr_wen | output | 1 | Condition field write enable |
| out_illegal | output | 1 | Instruction not recognised |

## Verification
The bench builds the unit at its default 64-bit operand width. At that width the most-negative and all-ones values are reachable, which is where signed and unsigned ordering disagree, and the bench drives them directly. Random operand pairs are mixed with forced ties, sign-boundary values and extended opcodes that differ from a legal one by a single bit. This exercises the strict-comparison tie rule, all three condition classes with both summary-overflow values, and rejection of near-miss encodings.

// File: rtl/minmax_pkg.sv
package minmax_pkg;

    localparam int INSN_W   = 32;
    localparam int REG_W    = 5;
    localparam int PRIM_W   = 6;
    localparam int XO_W     = 10;
    localparam int CR_W     = 4;

    localparam logic [PRIM_W-1:0] PRIMARY_OPC = 6'd22;

    localparam logic [XO_W-1:0] XO_MAX_S = 10'b0111001110;
    localparam logic [XO_W-1:0] XO_MAX_U = 10'b0011001110;
    localparam logic [XO_W-1:0] XO_MIN_S = 10'b0101001110;
    localparam logic [XO_W-1:0] XO_MIN_U = 10'b0001001110;

    typedef enum logic [1:0] {
        MM_MAX_S = 2'd0,
        MM_MAX_U = 2'd1,
        MM_MIN_S = 2'd2,
        MM_MIN_U = 2'd3
    } mm_op_e;

    typedef struct packed {
        logic             legal;
        mm_op_e           op;
        logic [REG_W-1:0] rt;
        logic             rec;
    } mm_dec_t;

    // Unpack fields: bit 0 of the instruction format is insn[31].
    function automatic logic [PRIM_W-1:0] f_primary(input logic [INSN_W-1:0] w);
        return w[31:26];
    endfunction

    function automatic logic [XO_W-1:0] f_xo(input logic [INSN_W-1:0] w);
        return w[10:1];
    endfunction

    function automatic logic [REG_W-1:0] f_rt(input logic [INSN_W-1:0] w);
        return w[25:21];
    endfunction

endpackage

// File: rtl/minmax_decode.sv
module minmax_decode
    import minmax_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output mm_dec_t           dec
);
    logic   prim_ok;
    logic   xo_ok;
    mm_op_e op_sel;

    assign prim_ok = (f_primary(insn) == PRIMARY_OPC);

    always_comb begin
        xo_ok  = 1'b1;
        op_sel = MM_MAX_S;
        unique case (f_xo(insn))
            XO_MAX_S: op_sel = MM_MAX_S;
            XO_MAX_U: op_sel = MM_MAX_U;
            XO_MIN_S: op_sel = MM_MIN_S;
            XO_MIN_U: op_sel = MM_MIN_U;
            default:  xo_ok  = 1'b0;
        endcase
    end

    always_comb begin
        dec.legal = prim_ok & xo_ok;
        dec.op    = op_sel;
        dec.rt    = f_rt(insn);
        dec.rec   = insn[0];
    end

endmodule

// File: rtl/minmax_select.sv
module minmax_select
    import minmax_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  mm_op_e          op,
    input  logic            so,
    output logic [XLEN-1:0] result,
    output logic [CR_W-1:0] cr
);
    localparam int MSB = XLEN - 1;

    logic is_signed;
    logic is_max;
    logic a_lt_b;
    logic b_lt_a;
    logic pick_a;

    assign is_signed = (op == MM_MAX_S) || (op == MM_MIN_S);
    assign is_max    = (op == MM_MAX_S) || (op == MM_MAX_U);

    // Flipping the sign bits maps two's-complement order onto unsigned order,
    // so a single pair of unsigned comparators serves both variants.
    logic [XLEN-1:0] ka;
    logic [XLEN-1:0] kb;
    assign ka = {a[MSB] ^ is_signed, a[MSB-1:0]};
    assign kb = {b[MSB] ^ is_signed, b[MSB-1:0]};

    assign a_lt_b = (ka < kb);
    assign b_lt_a = (kb < ka);

    // Strict comparisons: equal operands always resolve to b.
    assign pick_a = is_max ? b_lt_a : a_lt_b;
    assign result = pick_a ? a : b;

    logic res_neg;
    logic res_zero;
    assign res_neg  = result[MSB];
    assign res_zero = (result == '0);

    always_comb begin
        cr    = '0;
        cr[3] = res_neg;
        cr[2] = !res_neg && !res_zero;
        cr[1] = res_zero;
        cr[0] = so;
    end

endmodule

// File: rtl/minmax_unit.sv
module minmax_unit
    import minmax_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic              so_in,
    output logic [XLEN-1:0]   out_result,
    output logic [REG_W-1:0]  out_rt,
    output logic              out_wen,
    output logic [CR_W-1:0]   out_cr,
    output logic              out_cr_wen,
    output logic              out_illegal
);
    mm_dec_t         dec;
    logic [XLEN-1:0] sel_res;
    logic [CR_W-1:0] sel_cr;

    minmax_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    minmax_select #(.XLEN(XLEN)) u_sel (
        .a      (opa),
        .b      (opb),
        .op     (dec.op),
        .so     (so_in),
        .result (sel_res),
        .cr     (sel_cr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_wen     <= 1'b0;
            out_cr_wen  <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
            out_rt      <= '0;
            out_cr      <= '0;
        end else begin
            out_wen     <= in_valid && dec.legal;
            out_cr_wen  <= in_valid && dec.legal && dec.rec;
            out_illegal <= in_valid && !dec.legal;
            if (in_valid) begin
                out_result <= sel_res;
                out_rt     <= dec.rt;
                out_cr     <= sel_cr;
            end
        end
    end

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (!out_wen && !out_cr_wen && !out_illegal)); // R8

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_wen && !out_cr_wen)); // R7

    AST_CR_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
        out_cr_wen |-> out_wen); // R6

    AST_CR_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        out_cr_wen |-> ($countones(out_cr[3:1]) == 1)); // R6

    AST_RESULT_FROM_OPERAND: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_result == $past(opa) || out_result == $past(opb))); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_wen && !out_cr_wen && !out_illegal)); // R9

endmodule

// File: tb/minmax_unit_test.sv
module minmax_unit_test;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     insn = '0;
    logic [XLEN-1:0] opa = '0;
    logic [XLEN-1:0] opb = '0;
    logic            so_in = 1'b0;
    logic [XLEN-1:0] out_result;
    logic [4:0]      out_rt;
    logic            out_wen;
    logic [3:0]      out_cr;
    logic            out_cr_wen;
    logic            out_illegal;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    minmax_unit #(.XLEN(XLEN)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .opa(opa), .opb(opb), .so_in(so_in),
        .out_result(out_result), .out_rt(out_rt), .out_wen(out_wen),
        .out_cr(out_cr), .out_cr_wen(out_cr_wen), .out_illegal(out_illegal)
    );

    // op index: 0 smax, 1 umax, 2 smin, 3 umin (R1 encodings)
    function automatic logic [9:0] xo_of(input int op);
        case (op)
            0: return 10'b0111001110;
            1: return 10'b0011001110;
            2: return 10'b0101001110;
            default: return 10'b0001001110;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] ref_res(input int op,
            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        case (op)
            0: return ($signed(a) > $signed(b)) ? a : b;  // R2
            1: return (a > b) ? a : b;                    // R3
            2: return ($signed(a) < $signed(b)) ? a : b;  // R4
            default: return (a < b) ? a : b;              // R5
        endcase
    endfunction

    function automatic logic [3:0] ref_cr(input logic [XLEN-1:0] r, input logic so);
        if (r[XLEN-1]) return {3'b100, so};
        if (r == '0)   return {3'b001, so};
        return {3'b010, so};
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one instruction, check the registered outputs one edge later,
    // then check the following idle cycle.
    task automatic issue(input string req, input logic [5:0] prim,
            input logic [9:0] xo, input int op, input logic legal,
            input logic [4:0] rt, input logic rc,
            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
            input logic so, input logic [XLEN-1:0] exp_res);
        logic [XLEN-1:0] e;
        @(negedge clk);
        insn = {prim, rt, 5'($urandom), 5'($urandom), xo, rc};
        opa = a; opb = b; so_in = so; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        e = exp_res;
        if (legal) begin
            chk({req, " result"}, out_result, e);
            chk("R10 rt", 64'(out_rt), 64'(rt));
            chk("R1 wen", 64'(out_wen), 64'd1);
            chk("R7 illegal low", 64'(out_illegal), 64'd0);
            chk("R6 cr_wen", 64'(out_cr_wen), 64'(rc));
            if (rc) chk("R6 cr", 64'(out_cr), 64'(ref_cr(e, so)));
        end else begin
            chk("R7 illegal", 64'(out_illegal), 64'd1);
            chk("R7 wen", 64'(out_wen), 64'd0);
            chk("R7 cr_wen", 64'(out_cr_wen), 64'd0);
        end
        @(negedge clk);
        chk("R8 idle enables", 64'({out_wen, out_cr_wen, out_illegal}), 64'd0);
    endtask

    task automatic legal_op(input string req, input int op, input logic rc,
            input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic so);
        issue(req, 6'd22, xo_of(op), op, 1'b1, 5'($urandom), rc, a, b, so,
              ref_res(op, a, b));
    endtask

    function automatic logic [XLEN-1:0] pick_val();
        case ($urandom % 6)
            0: return 64'h8000_0000_0000_0000;
            1: return 64'h7fff_ffff_ffff_ffff;
            2: return '1;
            3: return '0;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R9 reset enables", 64'({out_wen, out_cr_wen, out_illegal}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 after reset", 64'({out_wen, out_cr_wen, out_illegal}), 64'd0);

        // Directed values
        issue("R2 smax", 6'd22, xo_of(0), 0, 1, 5'd3, 1'b0,
              64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 1'b0, 64'he1e5b9cc9864c4a8);
        issue("R4 smin", 6'd22, xo_of(2), 2, 1, 5'd3, 1'b1,
              64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 1'b0, 64'hc523e996a8ff6215);
        issue("R3 umax", 6'd22, xo_of(1), 1, 1, 5'd7, 1'b0,
              64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 1'b0, 64'he1e5b9cc9864c4a8);
        issue("R4 smin sign edge", 6'd22, xo_of(2), 2, 1, 5'd31, 1'b1,
              64'd1, 64'h8000_0000_0000_0000, 1'b0, 64'h8000_0000_0000_0000);
        issue("R5 umin sign edge", 6'd22, xo_of(3), 3, 1, 5'd1, 1'b1,
              64'd1, 64'h8000_0000_0000_0000, 1'b1, 64'd1);
        issue("R3 umax all-ones", 6'd22, xo_of(1), 1, 1, 5'd2, 1'b1,
              '1, 64'd5, 1'b0, '1);
        issue("R2 smax all-ones", 6'd22, xo_of(0), 0, 1, 5'd2, 1'b1,
              '1, 64'd5, 1'b1, 64'd5);
        issue("R6 zero result", 6'd22, xo_of(3), 3, 1, 5'd9, 1'b1,
              64'd0, 64'd12, 1'b1, 64'd0);
        // Ties resolve to b; use -0 vs 0 impossible, so use equal values
        for (int op = 0; op < 4; op++)
            legal_op("R2 tie", op, 1'b1, 64'h1234, 64'h1234, 1'b0);
        // Illegal encodings
        issue("R7 bad primary", 6'd21, xo_of(0), 0, 0, 5'd4, 1'b1, 64'd1, 64'd2, 1'b0, 64'd0);
        issue("R7 bad xo", 6'd22, 10'b0111001111, 0, 0, 5'd4, 1'b1, 64'd1, 64'd2, 1'b0, 64'd0);
        issue("R7 bad xo bit", 6'd22, 10'b1001001110, 0, 0, 5'd4, 1'b0, 64'd1, 64'd2, 1'b0, 64'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [XLEN-1:0] a, b;
            op = int'($urandom % 5);
            a = pick_val();
            b = ($urandom % 8 == 0) ? a : pick_val();
            if (op == 4) begin
                logic [9:0] x;
                x = xo_of(int'($urandom % 4)) ^ (10'd1 << ($urandom % 10));
                if (x != 10'b0111001110 && x != 10'b0011001110 &&
                    x != 10'b0101001110 && x != 10'b0001001110)
                    issue("R7 random illegal", 6'd22, x, 0, 0, 5'($urandom), 1'($urandom),
                          a, b, 1'($urandom), 64'd0);
            end else begin
                legal_op(op == 0 ? "R2 rand" : op == 1 ? "R3 rand" :
                         op == 2 ? "R4 rand" : "R5 rand",
                         op, 1'($urandom), a, b, 1'($urandom));
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule